// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a processor I/O bus and turns port accesses into configuration-space requests. Software first loads a 32-bit address register. It holds an enable flag together with the bus, device, function and register numbers of the target. A full-dword access to the data window, the port four bytes above, then becomes one configuration read or write. That request goes to a configuration target over a plain request/response handshake.

The processor access stalls until the target answers. If the target never answers, a timer ends the access after a fixed number of cycles, and a read then returns all ones. A partial-width write to the address port has no effect, and the reserved bits of the register always read back as zero. Software uses both facts to probe whether this mechanism is present. When the enable flag is clear, data-window reads return all ones and data-window writes are dropped, so no request reaches the target.

The I/O bus carries a dword port number and four byte enables. A requester raises `io_req` and holds it until it sees the one-cycle `io_ack` pulse.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address register reads zero, and `cfg_req` and `io_ack` are low.
- R2: A write to the address port (byte port 0x0CF8) with all four byte enables set stores the data with bits 30:24 and 1:0 cleared. Bit 31 is enable, 23:16 bus, 15:11 device, 10:8 function and 7:2 register offset. A read of that port returns the stored value.
- R3: A write to the address port with any byte enable clear leaves the register unchanged. This covers a byte write to 0x0CFB (enables 4'b1000) and a halfword write to 0x0CFA (enables 4'b1100).
- R4: With enable set, a full-dword read of the data window (byte port 0x0CFC) raises `cfg_req` once, with `cfg_we` low and the fields of the address register. `cfg_req` falls in the cycle after `cfg_rsp`. `io_ack` comes in that same cycle, carrying `cfg_rdata`.
- R5: With enable set, a full-dword write of the data window issues one request with `cfg_we` high and `cfg_wdata` equal to the written data. The access completes when the target responds.
- R6: With enable clear, including after zero is written to the address register, a data-window read returns 0xFFFFFFFF and a data-window write is discarded. Neither issues a request.
- R7: If `cfg_rsp` does not arrive within TMO_CYCLES cycles after `cfg_req` rises, the request is withdrawn and the access completes, a read returning 0xFFFFFFFF. A `cfg_rsp` with no request outstanding is ignored.
- R8: A data-window access with any byte enable clear issues no request. A read of this kind returns 0xFFFFFFFF.
- R9: An access to any other port is acknowledged, leaves the address register unchanged and issues no request. A read of this kind returns 0xFFFFFFFF.
- R10: Each access gets exactly one `io_ack` pulse, one cycle wide. Accesses that need no target complete one cycle after `io_req` is first sampled. `cfg_req` stays high until a response or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O access request, held until io_ack |
| io_we | input | 1 | 1 = port write, 0 = port read |
| io_addr | input | 14 | Dword port number (byte port bits 15:2) |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_req | output | 1 | Configuration request, held until response or timeout |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_fn | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rsp | input | 1 | Target response pulse |
| cfg_rdata | input | 32 | Target read data, valid with cfg_rsp |

## Verification
The assertions assume that a requester keeps `io_req` and its qualifiers steady until `io_ack` and drops `io_req` in the cycle it sees the pulse. They also assume that `cfg_rsp` is a single-cycle pulse. The stimulus tasks change the I/O inputs only on falling edges and release the request as soon as the acknowledge is seen. The target model answers only while a request is up. The one stray response is deliberately injected with the bridge idle, to show that it is ignored.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  localparam int DW = 32;

  // Writable bits of the address register: enable plus bus/dev/fn/offset.
  localparam logic [DW-1:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;

  localparam int EN_BIT   = 31;
  localparam int BUS_LSB  = 16;
  localparam int DEV_LSB  = 11;
  localparam int FN_LSB   = 8;
  localparam int OFS_LSB  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic [3:0]    be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic full_dword;
  assign full_dword = &be;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_stb && full_dword) begin
      q <= wdata & ADDR_KEEP_MASK;
    end
  end

  AST_PART_WR_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !full_dword) |=> $stable(q)) else $error("partial write changed address register"); // R3

endmodule

// File: rtl/cfgp_timer.sv
module cfgp_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (cnt == LAST);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("timeout counter overran"); // R7

endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
#(
  parameter int              IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-3:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [DW-1:0]    io_wdata,
  input  logic             cfg_en,
  input  logic [DW-1:0]    addr_rdback,
  input  logic             cfg_rsp,
  input  logic [DW-1:0]    cfg_rdata,
  input  logic             tmo,
  output logic             addr_wr,
  output logic             busy,
  output logic             io_ack,
  output logic [DW-1:0]    io_rdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [DW-1:0]    cfg_wdata
);

  localparam logic [IO_AW-1:0] DATA_PORT = ADDR_PORT + IO_AW'(4);
  localparam logic [IO_AW-3:0] ADDR_DW   = ADDR_PORT[IO_AW-1:2];
  localparam logic [IO_AW-3:0] DATA_DW   = DATA_PORT[IO_AW-1:2];

  seq_state_t state;
  logic hit_addr, hit_data, go_target;

  assign hit_addr  = (io_addr == ADDR_DW);
  assign hit_data  = (io_addr == DATA_DW);
  assign go_target = hit_data && (&io_be) && cfg_en;
  assign addr_wr   = (state == ST_IDLE) && io_req && io_we && hit_addr;
  assign busy      = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_wdata <= '0;
    end else begin
      io_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (io_req) begin
            if (go_target) begin
              cfg_req   <= 1'b1;
              cfg_we    <= io_we;
              cfg_wdata <= io_wdata;
              state     <= ST_WAIT;
            end else begin
              io_ack   <= 1'b1;
              io_rdata <= hit_addr ? addr_rdback : '1;
              state    <= ST_ACK;
            end
          end
        end
        ST_WAIT: begin
          if (cfg_rsp) begin
            cfg_req  <= 1'b0;
            io_ack   <= 1'b1;
            io_rdata <= cfg_rdata;
            state    <= ST_ACK;
          end else if (tmo) begin
            cfg_req  <= 1'b0;
            io_ack   <= 1'b1;
            io_rdata <= '1;
            state    <= ST_ACK;
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    io_ack |=> !io_ack) else $error("io_ack wider than one cycle"); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_rsp && !tmo) |=> cfg_req) else $error("request dropped early"); // R10

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_rsp) |=> (!cfg_req && io_ack)) else $error("response not completed"); // R4

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgp_pkg::*;
#(
  parameter int               IO_AW      = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT  = 16'h0CF8,
  parameter int               TMO_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-3:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic [31:0]      io_rdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [5:0]       cfg_reg,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_rsp,
  input  logic [31:0]      cfg_rdata
);

  logic [DW-1:0] addr_q;
  logic          addr_wr, busy, tmo, cfg_en;

  assign cfg_en  = addr_q[EN_BIT];
  assign cfg_bus = addr_q[BUS_LSB +: 8];
  assign cfg_dev = addr_q[DEV_LSB +: 5];
  assign cfg_fn  = addr_q[FN_LSB  +: 3];
  assign cfg_reg = addr_q[OFS_LSB +: 6];

  cfgp_addr_reg u_addr (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (addr_wr),
    .be     (io_be),
    .wdata  (io_wdata),
    .q      (addr_q)
  );

  cfgp_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .expire (tmo)
  );

  cfgp_seq #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .io_req      (io_req),
    .io_we       (io_we),
    .io_addr     (io_addr),
    .io_be       (io_be),
    .io_wdata    (io_wdata),
    .cfg_en      (cfg_en),
    .addr_rdback (addr_q),
    .cfg_rsp     (cfg_rsp),
    .cfg_rdata   (cfg_rdata),
    .tmo         (tmo),
    .addr_wr     (addr_wr),
    .busy        (busy),
    .io_ack      (io_ack),
    .io_rdata    (io_rdata),
    .cfg_req     (cfg_req),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata)
  );

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> cfg_en) else $error("request issued while disabled"); // R6

  AST_NO_REQ_PARTIAL: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> ($past(io_be) == 4'hF)) else $error("request from partial access"); // R8

  AST_ADDR_STABLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && $past(cfg_req)) |-> $stable(addr_q)) else $error("fields moved under request"); // R4

endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int NV = 17;
  localparam int VW = 119;

  logic        clk = 1'b0;
  logic        rst;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [13:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int n_total = 0;
  int n_fail = 0;
  bit done = 0;

  // target model state
  logic        tgt_on = 1'b1;
  logic        force_rsp = 1'b0;
  logic [31:0] tgt_data = '0;
  logic        prev_req = 1'b0;
  int          req_seen = 0;
  logic        cap_we;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [5:0]  cap_reg;
  logic [31:0] cap_wdata;

  cfg_port_bridge #(.TMO_CYCLES(TMO)) i_cfg_port_bridge (
    .clk(clk), .rst(rst),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
    .cfg_rsp(cfg_rsp), .cfg_rdata(cfg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (cfg_req && !prev_req) begin
      req_seen++;
      cap_we    = cfg_we;
      cap_bus   = cfg_bus;
      cap_dev   = cfg_dev;
      cap_fn    = cfg_fn;
      cap_reg   = cfg_reg;
      cap_wdata = cfg_wdata;
    end
    prev_req = cfg_req;
    if (cfg_rsp) begin
      cfg_rsp = 1'b0;
    end else if ((cfg_req && tgt_on) || force_rsp) begin
      cfg_rsp   = 1'b1;
      cfg_rdata = tgt_data;
    end
  end

  // {we, byte port, be, wdata, target answers, target data, expected read, requests}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 16'h0CF8, 4'hF, 32'hFF12_3A0E, 1'b0, 32'h0,         32'h0,         1'b0}, // R2
    {1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h8012_3A0C, 1'b0}, // R2
    {1'b1, 16'h0CF8, 4'h8, 32'h0,         1'b0, 32'h0,         32'h0,         1'b0}, // R3 byte 0x0CFB
    {1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h8012_3A0C, 1'b0}, // R3
    {1'b1, 16'h0CF8, 4'hC, 32'h0,         1'b0, 32'h0,         32'h0,         1'b0}, // R3 half 0x0CFA
    {1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h8012_3A0C, 1'b0}, // R3
    {1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1}, // R4
    {1'b1, 16'h0CFC, 4'hF, 32'h1234_5678, 1'b1, 32'h0,         32'h0,         1'b1}, // R5
    {1'b0, 16'h0CFC, 4'h3, 32'h0,         1'b1, 32'h0,         32'hFFFF_FFFF, 1'b0}, // R8
    {1'b1, 16'h0CFC, 4'h1, 32'hAA,        1'b1, 32'h0,         32'h0,         1'b0}, // R8
    {1'b0, 16'h0080, 4'hF, 32'h0,         1'b1, 32'h0,         32'hFFFF_FFFF, 1'b0}, // R9
    {1'b1, 16'h0CF4, 4'hF, 32'h0,         1'b1, 32'h0,         32'h0,         1'b0}, // R9
    {1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h8012_3A0C, 1'b0}, // R9
    {1'b1, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h0,         1'b0}, // R6
    {1'b0, 16'h0CFC, 4'hF, 32'h0,         1'b1, 32'h5555_AAAA, 32'hFFFF_FFFF, 1'b0}, // R6
    {1'b1, 16'h0CFC, 4'hF, 32'h7777_0000, 1'b1, 32'h0,         32'h0,         1'b0}, // R6
    {1'b0, 16'h0CF8, 4'hF, 32'h0,         1'b0, 32'h0,         32'h0,         1'b0}  // R6
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] port, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = port[15:2]; io_be = be; io_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!io_ack && lat < 1000);
    rd = io_rdata;
    io_req = 1'b0;
    if (lat >= 1000) check(1'b0, "R10 no ack", 32'(lat), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    report();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, base;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(io_ack == 1'b0, "R1 io_ack", {31'd0, io_ack}, 32'd0);
    check(cfg_req == 1'b0, "R1 cfg_req", {31'd0, cfg_req}, 32'd0);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h0, "R1 addr reg", rd, 32'h0);
    check(lat == 1, "R10 latency", 32'(lat), 32'd1);
    @(negedge clk);
    check(io_ack == 1'b0, "R10 pulse width", {31'd0, io_ack}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      tgt_on = v[65];
      tgt_data = v[64:33];
      base = req_seen;
      access(v[118], v[117:102], v[101:98], v[97:66], rd, lat);
      if (!v[118]) check(rd == v[32:1], $sformatf("R%0d vec %0d rdata", 0, i), rd, v[32:1]);
      check((req_seen - base) == int'(v[0]), $sformatf("vec %0d requests R4 R6 R8 R9", i),
            32'(req_seen - base), {31'd0, v[0]});
    end

    // Field routing for a read (R4)
    tgt_on = 1'b1;
    access(1'b1, 16'h0CF8, 4'hF, 32'h8012_3A0C, rd, lat);
    tgt_data = 32'h0BAD_F00D;
    access(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h0BAD_F00D, "R4 rdata", rd, 32'h0BAD_F00D);
    check(lat == 2, "R4 latency", 32'(lat), 32'd2);
    check({cap_we, cap_bus, cap_dev, cap_fn, cap_reg} == {1'b0, 8'h12, 5'd7, 3'd2, 6'd3},
          "R4 fields", 32'({cap_we, cap_bus, cap_dev, cap_fn, cap_reg}),
          32'({1'b0, 8'h12, 5'd7, 3'd2, 6'd3}));

    // All-ones fields and a write (R2, R5)
    access(1'b1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, rd, lat);
    access(1'b0, 16'h0CF8, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h80FF_FFFC, "R2 reserved cleared", rd, 32'h80FF_FFFC);
    access(1'b1, 16'h0CFC, 4'hF, 32'hCAFE_F00D, rd, lat);
    check(cap_we == 1'b1 && cap_wdata == 32'hCAFE_F00D, "R5 write data", cap_wdata, 32'hCAFE_F00D);
    check({cap_bus, cap_dev, cap_fn, cap_reg} == {8'hFF, 5'h1F, 3'h7, 6'h3F}, "R5 fields",
          32'({cap_bus, cap_dev, cap_fn, cap_reg}), 32'({8'hFF, 5'h1F, 3'h7, 6'h3F}));

    // Timeout (R7)
    tgt_on = 1'b0;
    base = req_seen;
    access(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check(rd == 32'hFFFF_FFFF, "R7 timeout rdata", rd, 32'hFFFF_FFFF);
    check(lat == TMO + 1, "R7 timeout latency", 32'(lat), 32'(TMO + 1));
    check(cfg_req == 1'b0, "R7 request withdrawn", {31'd0, cfg_req}, 32'd0);
    access(1'b1, 16'h0CFC, 4'hF, 32'h1, rd, lat);
    check(lat == TMO + 1, "R7 write timeout latency", 32'(lat), 32'(TMO + 1));
    check(req_seen - base == 2, "R7 one request each", 32'(req_seen - base), 32'd2);

    // Stray response while idle (R7)
    @(posedge clk); #1 force_rsp = 1'b1;
    @(posedge clk); #1 force_rsp = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(io_ack == 1'b0, "R7 stray response ignored", {31'd0, io_ack}, 32'd0);
    end
    tgt_on = 1'b1;
    tgt_data = 32'h1357_9BDF;
    access(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check(rd == 32'h1357_9BDF && lat == 2, "R7 recovery read", rd, 32'h1357_9BDF);

    report();
    $finish;
  end

endmodule